// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter

This block is a 16-bit up-counter for a single-clock-domain chip. It counts one of three sources: a tick at one quarter of the system clock, every system clock, or rising edges of an external input. A prescaler divides the chosen source by 1, 2, 4 or 8. The external input can be passed through two synchronizer flops or used directly. A gate unit can let the count run only while a chosen gate signal is active. The gate signal can be inverted, stretched by a toggle flip-flop to one full source period, or limited to exactly one pulse in a one-shot mode that software arms.

Software uses a byte-wide register bus. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. When `rd_en` is high on an edge while the low count byte is addressed, the high byte is held for a later read. Two level-type interrupt outputs report counter wrap and the end of a gate window.

The register map is: 0 control, 1 gate control, 2 count low byte, 3 count high byte, 4 flags. Control bits are [1:0] source, [3:2] prescale, [4] sync bypass and [5] run. Gate bits are [1:0] gate source, [2] gate enable, [3] invert, [4] toggle, [5] one-shot, [6] go/done and [7] live gate level (read-only). Flag bits are [0] wrap and [1] gate; writing a 1 to a flag bit clears it.

Top module: `gtmr_top`

## Requirements
- R1: Source field codes: 00 counts once every 4 system clocks while running, with the divider restarting when run is off. 01 counts every system clock. 10 counts external rising edges. 11 never counts.
- R2: In external mode, a rising edge counts only after a falling edge has been seen since the timer was last started in that mode.
- R3: Prescale codes 0..3 divide the selected source by 1, 2, 4 and 8. A write to either count byte restarts the prescaler.
- R4: With sync bypass at 0, an external rise is seen through two flops, so the count changes 3 clock edges after the input rises. With bypass at 1, the count changes on the first edge.
- R5: The counter changes only while run is 1 or when it is written. A count from 0xFFFF to 0x0000 sets the wrap flag (`irq_ovf`), and writing 1 to flag bit 0 clears it.
- R6: With gate enable at 1, counting happens only while the selected gate is active. Gate source codes are 00 `gate_pin`, 01 `gate_tmr`, 10 `gate_cmp1` and 11 `gate_cmp2`.
- R7: The invert bit makes a low gate signal the active level.
- R8: In toggle mode, each active-going gate edge flips a flip-flop that serves as the gate, so one window lasts one full gate period.
- R9: In one-shot mode, setting go arms one acquisition. The counter is enabled for exactly one gate pulse, and then hardware clears go.
- R10: Gate bit 7 reads the live gate level. The gate flag (`irq_gate`) is set when a gate window closes, or in one-shot mode when the acquisition ends.
- R11: A write to the high byte only fills a buffer. A write to the low byte loads both bytes together. A read of the low byte holds the high byte so that a following high-byte read matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (holds high byte on low-byte read) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| ext_in | input | 1 | External count input |
| gate_pin | input | 1 | Gate source 0 |
| gate_tmr | input | 1 | Gate source 1, match pulse from another timer |
| gate_cmp1 | input | 1 | Gate source 2 |
| gate_cmp2 | input | 1 | Gate source 3 |
| irq_ovf | output | 1 | Counter wrap flag |
| irq_gate | output | 1 | Gate window end flag |

## Verification
A register write takes effect on the edge it is sampled. With run first high after that edge, counting begins on the next edge, so a run of W idle cycles between start and stop writes covers W+2 counting edges. Gate inputs are combinational into the enable, so a gate held active over K edges yields exactly K counts. An external rise reaches the count 1 edge later with bypass and 3 edges later with two sync flops. The bench changes every input at a falling edge and takes reads 1 ns later, places each expected value at those edge counts, and sends expected/actual pairs through a queue to a monitor that compares them on the next falling edge.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
    localparam int CNT_W = 16;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_GATE = 3'd1;
    localparam logic [2:0] A_CLO  = 3'd2;
    localparam logic [2:0] A_CHI  = 3'd3;
    localparam logic [2:0] A_FLAG = 3'd4;

    typedef enum logic [1:0] {
        SRC_INSTR = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_OFF   = 2'b11
    } src_e;

    typedef struct packed {
        logic       run;
        logic       sync_byp;
        logic [1:0] psc;
        src_e       src;
    } ctrl_t;

    typedef struct packed {
        logic       one_shot;
        logic       toggle;
        logic       pol;
        logic       en;
        logic [1:0] gsrc;
    } gcfg_t;
endpackage

// File: rtl/gtmr_tick.sv
module gtmr_tick
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2,
    parameter int PSC_W       = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t cfg,
    input  logic  cnt_en,
    input  logic  psc_clr,
    input  logic  ext_in,
    output logic  tick
);
    localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

    typedef struct packed {
        logic [DIV_W-1:0]       div;
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   armed;
        logic [PSC_W-1:0]       pcnt;
    } tk_t;

    tk_t st_d, st_q;
    logic ext_cur, ext_act, ext_rise, raw, fire;
    logic [PSC_W-1:0] mask;

    always_comb begin
        st_d      = st_q;
        ext_cur   = cfg.sync_byp ? ext_in : st_q.sync[SYNC_STAGES-1];
        ext_act   = cfg.run && (cfg.src == SRC_EXT);
        ext_rise  = ext_act && st_q.armed && ext_cur && !st_q.prev;

        st_d.sync  = {st_q.sync[SYNC_STAGES-2:0], ext_in};
        st_d.prev  = ext_cur;
        st_d.armed = ext_act && (st_q.armed || (st_q.prev && !ext_cur));
        st_d.div   = cfg.run ? st_q.div + DIV_W'(1) : '0;

        case (cfg.src)
            SRC_INSTR: raw = cfg.run && (st_q.div == DIV_LAST);
            SRC_SYS:   raw = 1'b1;
            SRC_EXT:   raw = ext_rise;
            default:   raw = 1'b0;
        endcase

        fire = cnt_en && raw;
        mask = (PSC_W'(1) << cfg.psc) - PSC_W'(1);
        tick = fire && ((st_q.pcnt & mask) == mask);

        if (psc_clr)   st_d.pcnt = '0;
        else if (fire) st_d.pcnt = st_q.pcnt + PSC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: system-clock source with divide-by-1 ticks on every enabled cycle
    a_r1_sys_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && cfg.src == SRC_SYS && cfg.psc == 2'd0) |-> tick);

    // R2: no external count before a falling edge has armed the detector
    a_r2_unarmed_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src == SRC_EXT && !st_q.armed) |-> !tick);

    // R3: a count write restarts the prescaler
    a_r3_psc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        psc_clr |=> (st_q.pcnt == '0));
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate
    import gtmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gcfg_t      cfg,
    input  logic       go,
    input  logic [3:0] srcs,
    output logic       open,
    output logic       level,
    output logic       done,
    output logic       close_evt
);
    typedef struct packed {
        logic gprev;
        logic tff;
        logic gtprev;
        logic acq;
    } gt_t;

    gt_t st_d, st_q;
    logic g, g_rise, gt, gt_rise, gt_fall, armed;

    always_comb begin
        st_d    = st_q;
        g       = srcs[cfg.gsrc] ^ cfg.pol;
        g_rise  = g && !st_q.gprev;
        gt      = cfg.toggle ? st_q.tff : g;
        gt_rise = gt && !st_q.gtprev;
        gt_fall = !gt && st_q.gtprev;
        armed   = go && cfg.one_shot && cfg.en;

        st_d.gprev  = g;
        st_d.gtprev = gt;
        st_d.tff    = cfg.toggle ? (st_q.tff ^ g_rise) : 1'b0;

        if (!armed)                  st_d.acq = 1'b0;
        else if (st_q.acq && gt_fall) st_d.acq = 1'b0;
        else if (gt_rise)            st_d.acq = 1'b1;

        done      = armed && st_q.acq && gt_fall;
        close_evt = cfg.en && gt_fall && (!cfg.one_shot || st_q.acq);
        level     = gt;

        if (!cfg.en)           open = 1'b1;
        else if (cfg.one_shot) open = go && gt && (st_q.acq || gt_rise);
        else                   open = gt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: one-shot gating never opens without go
    a_r9_open_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cfg.one_shot && open) |-> go);

    // R8: toggle flip-flop flips on each active-going gate edge
    a_r8_tff_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.toggle && g_rise) |=> (!cfg.toggle || st_q.tff != $past(st_q.tff)));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 2,
    parameter int PSC_W       = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ext_in,
    input  logic       gate_pin,
    input  logic       gate_tmr,
    input  logic       gate_cmp1,
    input  logic       gate_cmp2,
    output logic       irq_ovf,
    output logic       irq_gate
);
    localparam int HI_LSB = CNT_W - 8;

    typedef struct packed {
        ctrl_t            ctrl;
        gcfg_t            gcfg;
        logic             go;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       hibuf;
        logic [7:0]       rdhi;
        logic             fovf;
        logic             fgate;
    } st_t;

    st_t st_d, st_q;
    logic wr_ctrl, wr_gate, wr_lo, wr_hi, wr_flag;
    logic gate_open, gate_level, gate_done, gate_close;
    logic tick, cnt_en, psc_clr, ovf_set;

    gtmr_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (st_q.gcfg),
        .go        (st_q.go),
        .srcs      ({gate_cmp2, gate_cmp1, gate_tmr, gate_pin}),
        .open      (gate_open),
        .level     (gate_level),
        .done      (gate_done),
        .close_evt (gate_close)
    );

    gtmr_tick #(
        .SYNC_STAGES (SYNC_STAGES),
        .DIV_W       (DIV_W),
        .PSC_W       (PSC_W)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (st_q.ctrl),
        .cnt_en  (cnt_en),
        .psc_clr (psc_clr),
        .ext_in  (ext_in),
        .tick    (tick)
    );

    always_comb begin
        st_d    = st_q;
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_gate = wr_en && (addr == A_GATE);
        wr_lo   = wr_en && (addr == A_CLO);
        wr_hi   = wr_en && (addr == A_CHI);
        wr_flag = wr_en && (addr == A_FLAG);
        cnt_en  = st_q.ctrl.run && gate_open;
        psc_clr = wr_lo || wr_hi;
        ovf_set = tick && !wr_lo && (st_q.cnt == '1);

        if (wr_ctrl) st_d.ctrl = ctrl_t'(wdata[5:0]);
        if (wr_gate) begin
            st_d.gcfg = gcfg_t'(wdata[5:0]);
            st_d.go   = wdata[6];
        end else if (gate_done) begin
            st_d.go = 1'b0;
        end

        if (wr_hi) st_d.hibuf = wdata;
        if (wr_lo)     st_d.cnt = {st_q.hibuf, wdata};
        else if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);

        if (rd_en && addr == A_CLO) st_d.rdhi = st_q.cnt[CNT_W-1:HI_LSB];

        st_d.fovf  = ovf_set    || (st_q.fovf  && !(wr_flag && wdata[0]));
        st_d.fgate = gate_close || (st_q.fgate && !(wr_flag && wdata[1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {2'b00, st_q.ctrl};
            A_GATE:  rdata = {gate_level, st_q.go, st_q.gcfg};
            A_CLO:   rdata = st_q.cnt[7:0];
            A_CHI:   rdata = st_q.rdhi;
            A_FLAG:  rdata = {6'b0, st_q.fgate, st_q.fovf};
            default: rdata = 8'h00;
        endcase
    end

    assign irq_ovf  = st_q.fovf;
    assign irq_gate = st_q.fgate;

    // R5: wrap lands on zero and raises the flag
    a_r5_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.cnt == '1 && !wr_lo) |=> (irq_ovf && st_q.cnt == '0));

    // R5: stopped timer holds its count unless written
    a_r5_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && !wr_lo) |=> $stable(st_q.cnt));

    // R9: end of one-shot acquisition clears go
    a_r9_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_done && !wr_gate) |=> !st_q.go);

    // R11: a high-byte write leaves the live count alone
    a_r11_hi_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !tick) |=> $stable(st_q.cnt));
endmodule

// File: tb/gtmr_top_tb_top.sv
`timescale 1ns/1ps
module gtmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ext_in = 1'b0;
    logic       gate_pin = 1'b0, gate_tmr = 1'b0, gate_cmp1 = 1'b0, gate_cmp2 = 1'b0;
    logic       irq_ovf, irq_gate;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        logic [15:0] v;
    } item_t;
    item_t exp_q[$];
    item_t act_q[$];

    always #2.5 clk = ~clk;

    gtmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_in(ext_in), .gate_pin(gate_pin),
        .gate_tmr(gate_tmr), .gate_cmp1(gate_cmp1), .gate_cmp2(gate_cmp2),
        .irq_ovf(irq_ovf), .irq_gate(irq_gate)
    );

    // monitor: pops expected/actual pairs and compares them
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (a.v !== e.v) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", e.tag, a.v, e.v);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        item_t e, a;
        e.tag = tag; e.v = exp;
        a.tag = tag; a.v = act;
        exp_q.push_back(e);
        act_q.push_back(a);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(3'd2, lo);
        rd(3'd3, hi);
        v = {hi, lo};
    endtask

    task automatic wr16(input logic [15:0] v);
        wr(3'd3, v[15:8]);
        wr(3'd2, v[7:0]);
    endtask

    function automatic logic [7:0] cb(input logic [1:0] src, input logic [1:0] psc,
                                      input logic byp, input logic run);
        return {2'b00, run, byp, psc, src};
    endfunction

    function automatic logic [7:0] gb(input logic [1:0] gs, input logic en, input logic pol,
                                      input logic tog, input logic os, input logic go);
        return {1'b0, go, os, tog, pol, en, gs};
    endfunction

    // run for W idle cycles between start and stop: W+2 counting edges
    task automatic meas(input logic [1:0] src, input logic [1:0] psc, input int w,
                        output logic [15:0] v);
        wr16(16'h0000);
        wr(3'd0, cb(src, psc, 1'b1, 1'b1));
        repeat (w) @(negedge clk);
        wr(3'd0, cb(src, psc, 1'b1, 1'b0));
        rd16(v);
    endtask

    task automatic set_src(input int s, input logic val);
        case (s)
            0: gate_pin = val;
            1: gate_tmr = val;
            2: gate_cmp1 = val;
            default: gate_cmp2 = val;
        endcase
    endtask

    task automatic gate_src_run(input int s, input int k, output logic [15:0] v);
        gate_pin = 1'b1; gate_tmr = 1'b1; gate_cmp1 = 1'b1; gate_cmp2 = 1'b1;
        set_src(s, 1'b0);
        wr16(16'h0000);
        wr(3'd1, gb(2'(s), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(3'd4, 8'h03);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b1));
        repeat (2) @(negedge clk);
        set_src(s, 1'b1);
        repeat (k) @(negedge clk);
        set_src(s, 1'b0);
        repeat (2) @(negedge clk);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b0));
        rd16(v);
    endtask

    task automatic ext_latency(input logic byp);
        logic [7:0] d;
        ext_in = 1'b1;
        wr16(16'h0000);
        wr(3'd0, cb(2'b10, 2'd0, byp, 1'b1));
        @(negedge clk); ext_in = 1'b0;
        repeat (5) @(negedge clk);
        ext_in = 1'b1; addr = 3'd2;
        #1 d = rdata;
        chk("R4 no change at rise", {8'h00, d}, 16'h0000);
        if (byp) begin
            @(negedge clk); #1 d = rdata;
            chk("R4 bypass count after 1 edge", {8'h00, d}, 16'h0001);
        end else begin
            repeat (2) @(negedge clk); #1 d = rdata;
            chk("R4 synced not yet after 2 edges", {8'h00, d}, 16'h0000);
            @(negedge clk); #1 d = rdata;
            chk("R4 synced count after 3 edges", {8'h00, d}, 16'h0001);
        end
        wr(3'd0, cb(2'b10, 2'd0, byp, 1'b0));
        ext_in = 1'b0;
    endtask

    task automatic ext_arming(input logic byp, output logic [15:0] v);
        ext_in = 1'b0;
        wr16(16'h0000);
        wr(3'd0, cb(2'b10, 2'd0, byp, 1'b1));
        repeat (3) @(negedge clk); ext_in = 1'b1;
        repeat (4) @(negedge clk); ext_in = 1'b0;
        repeat (4) @(negedge clk); ext_in = 1'b1;
        repeat (4) @(negedge clk); ext_in = 1'b0;
        repeat (4) @(negedge clk); ext_in = 1'b1;
        repeat (5) @(negedge clk);
        wr(3'd0, cb(2'b10, 2'd0, byp, 1'b0));
        ext_in = 1'b0;
        rd16(v);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        logic [7:0]  d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R5 reset irq_ovf", {15'b0, irq_ovf}, 16'h0000);
        chk("R10 reset irq_gate", {15'b0, irq_gate}, 16'h0000);
        rd16(v); chk("R5 reset count", v, 16'h0000);
        rd(3'd0, d); chk("R5 reset ctrl", {8'h00, d}, 16'h0000);

        // clock sources and prescaler
        meas(2'b01, 2'd0, 38, v); chk("R1 sys clock 40 edges", v, 16'd40);
        meas(2'b00, 2'd0, 38, v); chk("R1 quarter rate 40 edges", v, 16'd10);
        meas(2'b11, 2'd0, 38, v); chk("R1 code 11 never counts", v, 16'd0);
        meas(2'b01, 2'd1, 38, v); chk("R3 divide by 2", v, 16'd20);
        meas(2'b01, 2'd2, 38, v); chk("R3 divide by 4", v, 16'd10);
        meas(2'b01, 2'd3, 38, v); chk("R3 divide by 8", v, 16'd5);
        meas(2'b00, 2'd1, 38, v); chk("R3 quarter rate divide by 2", v, 16'd5);
        meas(2'b01, 2'd3, 2, v);  chk("R3 partial prescale no tick", v, 16'd0);
        meas(2'b01, 2'd3, 2, v);  chk("R3 count write restarts prescaler", v, 16'd0);

        // external input
        ext_arming(1'b1, v); chk("R2 first rise not counted (bypass)", v, 16'd2);
        ext_arming(1'b0, v); chk("R2 R1 external synced edges", v, 16'd2);
        ext_latency(1'b1);
        ext_latency(1'b0);

        // overflow
        wr(3'd4, 8'h03);
        wr16(16'hFFFD);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b1));
        repeat (1) @(negedge clk);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b0));
        rd16(v); chk("R5 wrap to zero", v, 16'h0000);
        chk("R5 wrap sets irq_ovf", {15'b0, irq_ovf}, 16'h0001);
        repeat (10) @(negedge clk);
        rd16(v); chk("R5 stopped count holds", v, 16'h0000);
        wr(3'd4, 8'h01);
        chk("R5 irq_ovf cleared", {15'b0, irq_ovf}, 16'h0000);

        // atomic write and coherent read
        wr16(16'h0000);
        wr(3'd3, 8'hAB);
        rd16(v); chk("R11 high write is buffered", v, 16'h0000);
        wr(3'd2, 8'hCD);
        rd16(v); chk("R11 low write commits both", v, 16'hABCD);
        wr(3'd3, 8'h00);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b1));
        wr(3'd2, 8'hFE);
        rd16(v); chk("R11 coherent read across carry", v, 16'h00FF);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b0));

        // gate sources
        gate_src_run(0, 5, v); chk("R6 gate pin window", v, 16'd5);
        chk("R10 gate flag on window close", {15'b0, irq_gate}, 16'h0001);
        wr(3'd4, 8'h02);
        chk("R10 gate flag cleared", {15'b0, irq_gate}, 16'h0000);
        gate_src_run(1, 6, v); chk("R6 gate timer match window", v, 16'd6);
        gate_src_run(2, 7, v); chk("R6 gate cmp1 window", v, 16'd7);
        gate_src_run(3, 8, v); chk("R6 gate cmp2 window", v, 16'd8);
        gate_pin = 1'b0; gate_tmr = 1'b0; gate_cmp1 = 1'b0; gate_cmp2 = 1'b0;

        // level readback and polarity
        wr(3'd1, gb(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        gate_pin = 1'b1;
        rd(3'd1, d); chk("R10 level high", {15'b0, d[7]}, 16'h0001);
        gate_pin = 1'b0;
        rd(3'd1, d); chk("R10 level low", {15'b0, d[7]}, 16'h0000);
        gate_pin = 1'b1;
        wr16(16'h0000);
        wr(3'd1, gb(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        rd(3'd1, d); chk("R7 R10 inverted level", {15'b0, d[7]}, 16'h0000);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b1));
        repeat (2) @(negedge clk);
        gate_pin = 1'b0;
        repeat (9) @(negedge clk);
        gate_pin = 1'b1;
        repeat (2) @(negedge clk);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b0));
        rd16(v); chk("R7 active-low gate window", v, 16'd9);
        gate_pin = 1'b0;

        // toggle mode
        wr16(16'h0000);
        wr(3'd1, gb(2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b1));
        repeat (2) @(negedge clk); gate_pin = 1'b1;
        repeat (2) @(negedge clk); gate_pin = 1'b0;
        repeat (4) @(negedge clk); gate_pin = 1'b1;
        repeat (2) @(negedge clk); gate_pin = 1'b0;
        repeat (6) @(negedge clk);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b0));
        rd16(v); chk("R8 toggle window equals period", v, 16'd6);

        // one-shot mode
        wr16(16'h0000);
        wr(3'd1, gb(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
        wr(3'd4, 8'h03);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b1));
        repeat (2) @(negedge clk); gate_pin = 1'b1;
        repeat (3) @(negedge clk); gate_pin = 1'b0;
        repeat (3) @(negedge clk); gate_pin = 1'b1;
        repeat (5) @(negedge clk); gate_pin = 1'b0;
        repeat (2) @(negedge clk);
        wr(3'd0, cb(2'b01, 2'd0, 1'b1, 1'b0));
        rd16(v); chk("R9 one pulse counted", v, 16'd3);
        rd(3'd1, d); chk("R9 go cleared by hardware", {15'b0, d[6]}, 16'h0000);
        chk("R10 acquisition end sets gate flag", {15'b0, irq_gate}, 16'h0001);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule